// File: doc/BRIEF.md
# Reset Sequencing and Synchronization Controller

This block turns one asynchronous, active-low board reset into clean per-domain resets for a chip with several clock domains. Each domain gets a reset that drops at once, with no clock running, and rises only on that domain's own clock edge, two edges after the board reset is gone. Release is also held off until the clock generator reports lock. If lock is lost, the domains fall back into reset.

For the sequence-control state machines in the primary domain (domain 0), the block drives a separate synchronous hold. This hold stays high for a short window after the primary domain leaves reset. A host processor can also raise it again with a one-cycle software request, without touching the board pin. While the hold is active, every chip output enable is forced off, so the pads float.

A single status flag tells a host that every domain has left reset and the hold has cleared.

Top module: `reset_seq_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, every bit of `dom_rst_n` is 0 and `seq_hold` is 1. This takes effect immediately, without any clock edge.
- R2: With `clk_locked` steady high, after `rst_pin_n` rises, `dom_rst_n[0]` stays 0 across the first rising edge of `clk_dom[0]` and becomes 1 after the second.
- R3: Every domain has its own synchronizer on its own clock. `dom_rst_n[i]` releases on the second rising edge of `clk_dom[i]` after the pin rises, independently of the other domains.
- R4: A domain's reset is released only after `clk_locked` has been seen high on a clock edge. If `clk_locked` is sampled low on two successive edges of a domain's clock, that domain's reset is asserted.
- R5: `seq_hold` stays 1 for HOLD_CYCLES (default 2) edges of `clk_dom[0]` after `dom_rst_n[0]` rises.
- R6: `seq_hold` is 1 whenever `dom_rst_n[0]` is 0, so the hold never ends before the primary domain reset.
- R7: A one-cycle high pulse on `sw_rst_req`, sampled on a `clk_dom[0]` edge, makes `seq_hold` 1 for the next HOLD_CYCLES cycles and then 0. The pulse leaves `dom_rst_n` unchanged.
- R8: While `seq_hold` is 1, `pad_oe` is all zeros (pads high impedance). Otherwise `pad_oe` equals `func_oe`. `pad_do` always equals `func_do`.
- R9: `all_ready` is 1 exactly when every bit of `dom_rst_n` is 1 and `seq_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dom | input | NUM_DOMAINS | One clock per domain; bit 0 is the primary domain |
| rst_pin_n | input | 1 | Board reset, asynchronous, active low |
| clk_locked | input | 1 | Clock generator lock indication |
| sw_rst_req | input | 1 | One-cycle host reset request, synchronous to clk_dom[0] |
| func_oe | input | PAD_W | Functional output enables from the core |
| func_do | input | PAD_W | Functional output data from the core |
| dom_rst_n | output | NUM_DOMAINS | Per-domain reset, active low, async assert, sync release |
| seq_hold | output | 1 | Synchronous hold for sequence controllers in domain 0 |
| pad_oe | output | PAD_W | Gated enables to the pad buffers (0 = high impedance) |
| pad_do | output | PAD_W | Data to the pad buffers |
| all_ready | output | 1 | Every domain released and hold cleared |

## Verification
The bench releases the board reset and checks the exact edge on which each domain comes out of reset. A chain one flop short would release a cycle early; a chain tied to the wrong clock would release on the wrong domain's edge. It drops lock for a single cycle and for a long stretch. A design that ignored lock would stay released, and one that filtered too hard would miss the long loss. It fires a one-cycle software request, and it pulls the pin low between clock edges. A hold that was not stretched would last one cycle, and a reset that waited for a clock would be caught still released right after the pin falls.

// File: rtl/rstc_pkg.sv
`timescale 1ns/10ps
package rstc_pkg;
    // Two-stage release synchronizer state for one clock domain
    typedef struct packed {
        logic meta;   // first stage, may go metastable on release
        logic sync;   // second stage, clean domain reset (active low)
    } chain_t;

    // Minimum hold window the sequence controllers need
    localparam int unsigned MIN_HOLD = 2;
endpackage

// File: rtl/rstc_sync_chain.sv
`timescale 1ns/10ps
module rstc_sync_chain
    import rstc_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic qual,      // released level only while clock generator is locked
    output logic rst_n
);
    chain_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = qual;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rst_n = st_q.sync;
endmodule

// File: rtl/rstc_seq_hold.sv
`timescale 1ns/10ps
module rstc_seq_hold #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic dom_rel,   // primary domain reset released (1)
    input  logic sw_req,    // one-cycle host request
    output logic hold
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] left;
    } hold_st_t;

    hold_st_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (!dom_rel || sw_req) begin
            hs_d.left = HOLD_LOAD;
        end else if (hs_q.left != '0) begin
            hs_d.left = hs_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) hs_q.left <= HOLD_LOAD;
        else         hs_q      <= hs_d;
    end

    // Hold covers the domain reset itself plus the stretch window
    assign hold = !dom_rel || (hs_q.left != '0);
endmodule

// File: rtl/rstc_pad_gate.sv
`timescale 1ns/10ps
module rstc_pad_gate #(
    parameter int PAD_W = 8
) (
    input  logic             hold,
    input  logic             dom_rel,
    input  logic [PAD_W-1:0] func_oe,
    input  logic [PAD_W-1:0] func_do,
    output logic [PAD_W-1:0] pad_oe,
    output logic [PAD_W-1:0] pad_do
);
    logic quiet;

    always_comb quiet = hold || !dom_rel;

    for (genvar pb = 0; pb < PAD_W; pb++) begin : g_pad
        always_comb begin
            pad_oe[pb] = quiet ? 1'b0 : func_oe[pb];
            pad_do[pb] = func_do[pb];
        end
    end
endmodule

// File: rtl/reset_seq_ctrl.sv
`timescale 1ns/10ps
module reset_seq_ctrl
    import rstc_pkg::*;
#(
    parameter int NUM_DOMAINS = 2,
    parameter int HOLD_CYCLES = 2,
    parameter int PAD_W       = 8
) (
    input  logic [NUM_DOMAINS-1:0] clk_dom,
    input  logic                   rst_pin_n,
    input  logic                   clk_locked,
    input  logic                   sw_rst_req,
    input  logic [PAD_W-1:0]       func_oe,
    input  logic [PAD_W-1:0]       func_do,
    output logic [NUM_DOMAINS-1:0] dom_rst_n,
    output logic                   seq_hold,
    output logic [PAD_W-1:0]       pad_oe,
    output logic [PAD_W-1:0]       pad_do,
    output logic                   all_ready
);
    localparam int HOLD_EFF = (HOLD_CYCLES < int'(MIN_HOLD)) ? int'(MIN_HOLD) : HOLD_CYCLES;

    // One synchronizer per clock domain
    for (genvar gd = 0; gd < NUM_DOMAINS; gd++) begin : g_dom
        rstc_sync_chain u_chain (
            .clk    (clk_dom[gd]),
            .arst_n (rst_pin_n),
            .qual   (clk_locked),
            .rst_n  (dom_rst_n[gd])
        );
    end

    rstc_seq_hold #(.HOLD_CYCLES(HOLD_EFF)) u_hold (
        .clk     (clk_dom[0]),
        .arst_n  (rst_pin_n),
        .dom_rel (dom_rst_n[0]),
        .sw_req  (sw_rst_req),
        .hold    (seq_hold)
    );

    rstc_pad_gate #(.PAD_W(PAD_W)) u_pads (
        .hold    (seq_hold),
        .dom_rel (dom_rst_n[0]),
        .func_oe (func_oe),
        .func_do (func_do),
        .pad_oe  (pad_oe),
        .pad_do  (pad_do)
    );

    always_comb all_ready = (&dom_rst_n) && !seq_hold;
endmodule

// File: rtl/reset_seq_ctrl_chk.sv
`timescale 1ns/10ps
module reset_seq_ctrl_chk #(
    parameter int NUM_DOMAINS = 2,
    parameter int PAD_W       = 8
) (
    input logic [NUM_DOMAINS-1:0] clk_dom,
    input logic                   rst_pin_n,
    input logic                   clk_locked,
    input logic                   sw_rst_req,
    input logic [PAD_W-1:0]       func_oe,
    input logic [NUM_DOMAINS-1:0] dom_rst_n,
    input logic                   seq_hold,
    input logic [PAD_W-1:0]       pad_oe,
    input logic                   all_ready
);
    for (genvar gi = 0; gi < NUM_DOMAINS; gi++) begin : g_chk
        assert_pin_asserts_R1: assert property (@(posedge clk_dom[gi])
            !rst_pin_n |-> !dom_rst_n[gi]);

        assert_lock_loss_R4: assert property (@(posedge clk_dom[gi]) disable iff (!rst_pin_n)
            (!$past(clk_locked) && !$past(clk_locked, 2)) |-> !dom_rst_n[gi]);
    end

    assert_hold_after_release_R5: assert property (@(posedge clk_dom[0]) disable iff (!rst_pin_n)
        $rose(dom_rst_n[0]) |-> seq_hold ##1 seq_hold);

    assert_hold_covers_reset_R6: assert property (@(posedge clk_dom[0])
        !dom_rst_n[0] |-> seq_hold);

    assert_sw_stretch_R7: assert property (@(posedge clk_dom[0]) disable iff (!rst_pin_n)
        sw_rst_req |=> seq_hold ##1 seq_hold);

    assert_pads_quiet_R8: assert property (@(posedge clk_dom[0])
        seq_hold |-> (pad_oe == '0));

    assert_pads_subset_R8: assert property (@(posedge clk_dom[0])
        (pad_oe & ~func_oe) == '0);

    assert_ready_pads_R9: assert property (@(posedge clk_dom[0]) disable iff (!rst_pin_n)
        all_ready |-> (pad_oe == func_oe));
endmodule

bind reset_seq_ctrl reset_seq_ctrl_chk #(
    .NUM_DOMAINS (NUM_DOMAINS),
    .PAD_W       (PAD_W)
) u_chk (
    .clk_dom    (clk_dom),
    .rst_pin_n  (rst_pin_n),
    .clk_locked (clk_locked),
    .sw_rst_req (sw_rst_req),
    .func_oe    (func_oe),
    .dom_rst_n  (dom_rst_n),
    .seq_hold   (seq_hold),
    .pad_oe     (pad_oe),
    .all_ready  (all_ready)
);

// File: tb/reset_seq_ctrl_test.sv
`timescale 1ns/10ps
module reset_seq_ctrl_test;
    localparam int ND = 2;
    localparam int HC = 2;
    localparam int PW = 8;

    logic clk0 = 1'b0;
    logic clk1 = 1'b0;
    logic rst_pin_n = 1'b1;
    logic clk_locked = 1'b0;
    logic sw_rst_req = 1'b0;
    logic [PW-1:0] func_oe = '0;
    logic [PW-1:0] func_do = '0;
    logic [ND-1:0] dom_rst_n;
    logic seq_hold;
    logic [PW-1:0] pad_oe;
    logic [PW-1:0] pad_do;
    logic all_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    // 200 MHz primary clock; secondary domain edges never coincide with stimulus
    always #2.5 clk0 = ~clk0;
    initial begin
        #1.1;
        forever begin
            clk1 = 1'b1; #4;
            clk1 = 1'b0; #4;
        end
    end

    reset_seq_ctrl #(.NUM_DOMAINS(ND), .HOLD_CYCLES(HC), .PAD_W(PW)) uut (
        .clk_dom    ({clk1, clk0}),
        .rst_pin_n  (rst_pin_n),
        .clk_locked (clk_locked),
        .sw_rst_req (sw_rst_req),
        .func_oe    (func_oe),
        .func_do    (func_do),
        .dom_rst_n  (dom_rst_n),
        .seq_hold   (seq_hold),
        .pad_oe     (pad_oe),
        .pad_do     (pad_do),
        .all_ready  (all_ready)
    );

    // Behavioural reference: lock seen on the previous edge, released state, hold countdown
    bit lk0 = 1'b0, lk1 = 1'b0;
    bit up0 = 1'b0, up1 = 1'b0;
    bit was0 = 1'b0;
    int left = HC;

    always @(posedge clk0) begin
        if (!rst_pin_n) begin
            lk0 = 1'b0; up0 = 1'b0; left = HC;
        end else begin
            was0 = up0;
            up0  = lk0;
            lk0  = clk_locked;
            if (!was0 || sw_rst_req) left = HC;
            else if (left > 0)       left = left - 1;
        end
    end

    always @(posedge clk1) begin
        if (!rst_pin_n) begin
            lk1 = 1'b0; up1 = 1'b0;
        end else begin
            up1 = lk1;
            lk1 = clk_locked;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Compare on every primary clock, away from the active edge
    always @(negedge clk0) begin
        if (run_cmp && !done) begin
            bit e0, e1, es, er;
            logic [PW-1:0] eo;
            e0 = rst_pin_n && up0;
            e1 = rst_pin_n && up1;
            es = !e0 || (left > 0);
            eo = es ? '0 : func_oe;
            er = e0 && e1 && !es;
            check(dom_rst_n[0] === e0, "R2", "dom_rst_n[0]", 32'(dom_rst_n[0]), 32'(e0));
            check(dom_rst_n[1] === e1, "R3", "dom_rst_n[1]", 32'(dom_rst_n[1]), 32'(e1));
            check(seq_hold === es, "R5", "seq_hold", 32'(seq_hold), 32'(es));
            check(pad_oe === eo, "R8", "pad_oe", 32'(pad_oe), 32'(eo));
            check(pad_do === func_do, "R8", "pad_do", 32'(pad_do), 32'(func_do));
            check(all_ready === er, "R9", "all_ready", 32'(all_ready), 32'(er));
            if (dom_rst_n[0] === 1'b0)
                check(seq_hold === 1'b1, "R6", "seq_hold during reset", 32'(seq_hold), 32'd1);
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk0);
            #1.25;
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        #0.25;
        rst_pin_n = 1'b0;
        func_oe   = 8'hFF;
        func_do   = 8'hA5;
        run_cmp   = 1'b1;
        step(3);
        // R1: reset state with the pin low
        check(dom_rst_n === 2'b00, "R1", "dom_rst_n in reset", 32'(dom_rst_n), 32'd0);
        check(seq_hold === 1'b1, "R1", "seq_hold in reset", 32'(seq_hold), 32'd1);
        check(pad_oe === 8'h00, "R8", "pad_oe in reset", 32'(pad_oe), 32'd0);

        clk_locked = 1'b1;
        step(2);
        rst_pin_n = 1'b1;
        // R2: first edge keeps reset, second releases
        @(posedge clk0); #0.3;
        check(dom_rst_n[0] === 1'b0, "R2", "after first edge", 32'(dom_rst_n[0]), 32'd0);
        @(posedge clk0); #0.3;
        check(dom_rst_n[0] === 1'b1, "R2", "after second edge", 32'(dom_rst_n[0]), 32'd1);
        check(seq_hold === 1'b1, "R5", "hold right after release", 32'(seq_hold), 32'd1);

        step(12);
        check(all_ready === 1'b1, "R9", "ready after release", 32'(all_ready), 32'd1);

        func_oe = 8'h3C; func_do = 8'h5A; step(1);
        func_oe = 8'h00; func_do = 8'hFF; step(1);
        func_oe = 8'hF0; func_do = 8'h0F; step(1);

        // R7: one-cycle host request
        sw_rst_req = 1'b1;
        step(1);
        sw_rst_req = 1'b0;
        check(seq_hold === 1'b1, "R7", "hold cycle 1", 32'(seq_hold), 32'd1);
        check(dom_rst_n === 2'b11, "R7", "domains untouched", 32'(dom_rst_n), 32'd3);
        check(pad_oe === 8'h00, "R8", "pads quiet on sw hold", 32'(pad_oe), 32'd0);
        step(1);
        check(seq_hold === 1'b1, "R7", "hold cycle 2", 32'(seq_hold), 32'd1);
        step(1);
        check(seq_hold === 1'b0, "R7", "hold ended", 32'(seq_hold), 32'd0);

        // Short lock glitch, then long loss
        clk_locked = 1'b0; step(1);
        clk_locked = 1'b1; step(6);
        clk_locked = 1'b0; step(5);
        check(dom_rst_n === 2'b00, "R4", "lock lost", 32'(dom_rst_n), 32'd0);
        check(all_ready === 1'b0, "R9", "not ready on lock loss", 32'(all_ready), 32'd0);
        clk_locked = 1'b1; step(8);
        check(all_ready === 1'b1, "R4", "recovered after lock", 32'(all_ready), 32'd1);

        // R1: asynchronous assert between edges
        rst_pin_n = 1'b0;
        #0.2;
        check(dom_rst_n === 2'b00, "R1", "async assert", 32'(dom_rst_n), 32'd0);
        check(seq_hold === 1'b1, "R6", "hold on async assert", 32'(seq_hold), 32'd1);
        step(3);

        // R4: pin released while unlocked stays in reset
        clk_locked = 1'b0;
        rst_pin_n  = 1'b1;
        step(5);
        check(dom_rst_n === 2'b00, "R4", "no release without lock", 32'(dom_rst_n), 32'd0);
        clk_locked = 1'b1;
        step(10);
        check(all_ready === 1'b1, "R9", "final ready", 32'(all_ready), 32'd1);
        step(2);
        finish_up();
    end
endmodule